// File: doc/BRIEF.md
# Dual-Die Flash Target Emulator

This block is a synthesizable device-side stand-in for two flash dies that sit behind one chip enable. A host drives an 8-bit byte bus qualified by a command-latch strobe, an address-latch strobe and a one-cycle write strobe. The block decodes program, cache program, two-plane program and erase sequences, and uses one bit of the final row address byte to hand each operation to die 0 or die 1. Each die runs its own busy timer, with durations set by parameters. The block has one shared ready/busy line and returns a status byte for the die chosen by a die-select status command. Array contents are not modelled.

The front-end decoder has eight states. F_IDLE waits for a command. 80h moves to F_PADDR, which counts COL_CYCLES+ROW_CYCLES address bytes. On the last byte it goes to F_PDATA if the addressed die is ready; otherwise it raises an error and goes to F_DROP. From F_PDATA, 85h moves to F_RCOL for COL_CYCLES column bytes and then back to F_PDATA. 10h, 15h or 11h launches the die and returns to F_IDLE. 60h moves to F_EADDR, which counts ROW_CYCLES bytes and goes to F_EWAIT, or to F_DROP if the die is not idle. In F_EWAIT, a second 60h returns to F_EADDR as a second-plane group, and D0h launches the erase. 78h moves to F_SADDR, whose last row byte selects the status die before it returns to F_IDLE. F_DROP ignores the rest of a rejected sequence: its confirm byte silently returns it to F_IDLE.

Each die engine has seven states. D_IDLE is done. D_PROG (10h) and D_ERASE (D0h) return to D_IDLE when their timer ends. D_CREL (15h) runs CACHE_T cycles and then enters D_CBG. D_CBG is the background program: it is ready, runs PROG_T cycles, then returns to D_IDLE. D_PWAIT (11h) runs PLANE_T cycles and then enters D_PARM, where the die is ready and waits for the second plane. A die in D_IDLE, D_CBG or D_PARM accepts a program launch. Only D_IDLE accepts an erase.

Top module: `dual_die_emul`

## Requirements
- R1: Bit DIE_BIT (default 2) of the last address byte of a sequence selects the die: 0 means die 0 and 1 means die 1. An operation on one die leaves the other die's status unchanged.
- R2: `rb` is 1 only when both dies are ready. It is 0 while either die is in D_PROG, D_ERASE, D_CREL or D_PWAIT. After reset it is 1.
- R3: The sequence 80h, five address bytes, data bytes, 10h keeps the die busy for exactly PROG_T cycles (default 64). During that time its status reads 00h, and afterwards it reads 60h.
- R4: The status byte is: bit 6 = ready to accept a new operation, bit 5 = every operation on that die is finished, all other bits 0. Bit 5 is never 1 while bit 6 is 0.
- R5: Ending a program with 15h makes the die busy for CACHE_T cycles (default 8). The die then reads 40h for PROG_T cycles and finally reads 60h. Another cache program is accepted while the die reads 40h.
- R6: 78h followed by three row bytes selects the die whose status is returned on each read strobe. After reset, die 0 is selected.
- R7: Ending a program with 11h makes the die busy for PLANE_T cycles (default 4). The die then reads 40h until a second 80h sequence, which is accepted and confirmed with 10h.
- R8: 60h, three row bytes, D0h makes the die busy for ERASE_T cycles (default 256). A two-plane form, 60h+rows, 60h+rows, D0h, behaves the same.
- R9: Inside a program data phase, 85h followed by two column bytes is accepted, and the later 10h still launches the program. An 85h outside a data phase pulses `proto_err` for one cycle.
- R10: A program addressed to a die that is not ready, or an erase addressed to a die that is not idle (bit 5 = 0), pulses `proto_err` on its last address byte. The rest of that sequence is ignored silently, and the die's busy period ends at its original time.
- R11: While one die is busy, an operation to the other die is accepted. `rb` stays 0 until the later of the two operations finishes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cle | input | 1 | Byte on `din` is a command |
| ale | input | 1 | Byte on `din` is an address |
| we | input | 1 | One-cycle write strobe for `din` |
| re | input | 1 | Read strobe; loads `dout` with the status of the selected die |
| din | input | 8 | Command, address or data byte |
| dout | output | 8 | Status byte captured on the last read strobe |
| rb | output | 1 | Shared ready (1) / busy (0) |
| proto_err | output | 1 | One-cycle pulse on a rejected command or sequence |

## Verification
The bench measures every busy period to the exact cycle. A timer that is off by one, or an error case that reloads the timer, therefore shows up as a wrong count. It checks for status 40h inside the cache and two-plane windows. A design that tied ready to done would read 00h there, and one that released the die early would read 60h. It interleaves a program on die 0 with an erase on die 1 and expects `rb` to stay low for the full combined span while die 0 already reads 60h; a ready line that follows one die only would rise too early. It also sends a program to a busy die and an erase to a die in background programming, and checks that each is flagged and that neither changes when the busy period ends.

// File: rtl/nand_emul_pkg.sv
package nand_emul_pkg;

    localparam int NUM_DIES = 2;

    localparam logic [7:0] CMD_PROG  = 8'h80;
    localparam logic [7:0] CMD_CONF  = 8'h10;
    localparam logic [7:0] CMD_CACHE = 8'h15;
    localparam logic [7:0] CMD_PLANE = 8'h11;
    localparam logic [7:0] CMD_ERASE = 8'h60;
    localparam logic [7:0] CMD_ECONF = 8'hD0;
    localparam logic [7:0] CMD_RAND  = 8'h85;
    localparam logic [7:0] CMD_STAT  = 8'h78;

    typedef enum logic [2:0] {
        D_IDLE, D_PROG, D_CREL, D_CBG, D_PWAIT, D_PARM, D_ERASE
    } die_st_t;

    typedef enum logic [2:0] {
        F_IDLE, F_PADDR, F_PDATA, F_RCOL, F_EADDR, F_EWAIT, F_SADDR, F_DROP
    } fe_st_t;

    typedef enum logic [1:0] {
        OP_PROG, OP_CACHE, OP_PLANE, OP_ERASE
    } op_t;

endpackage

// File: rtl/nand_die_engine.sv
module nand_die_engine
    import nand_emul_pkg::*;
#(
    parameter int PROG_T  = 64,
    parameter int ERASE_T = 256,
    parameter int CACHE_T = 8,
    parameter int PLANE_T = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    input  op_t  op,
    output logic rdy,
    output logic done
);

    localparam int MAX_A = (PROG_T > ERASE_T) ? PROG_T : ERASE_T;
    localparam int MAX_B = (CACHE_T > PLANE_T) ? CACHE_T : PLANE_T;
    localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CW    = $clog2(MAX_T + 1);
    localparam logic [CW-1:0] PROG_LD  = CW'(PROG_T - 1);
    localparam logic [CW-1:0] ERASE_LD = CW'(ERASE_T - 1);
    localparam logic [CW-1:0] CACHE_LD = CW'(CACHE_T - 1);
    localparam logic [CW-1:0] PLANE_LD = CW'(PLANE_T - 1);

    die_st_t        st, st_n;
    logic [CW-1:0]  cnt, cnt_n;

    // next state
    always_comb begin
        st_n  = st;
        cnt_n = cnt;
        unique case (st)
            D_IDLE, D_CBG, D_PARM: begin
                if (go) begin
                    unique case (op)
                        OP_PROG:  begin st_n = D_PROG;  cnt_n = PROG_LD;  end
                        OP_CACHE: begin st_n = D_CREL;  cnt_n = CACHE_LD; end
                        OP_PLANE: begin st_n = D_PWAIT; cnt_n = PLANE_LD; end
                        OP_ERASE: begin st_n = D_ERASE; cnt_n = ERASE_LD; end
                        default:  ;
                    endcase
                end else if (st == D_CBG) begin
                    if (cnt == '0) st_n = D_IDLE;
                    else           cnt_n = cnt - 1'b1;
                end
            end
            D_PROG, D_ERASE: begin
                if (cnt == '0) st_n = D_IDLE;
                else           cnt_n = cnt - 1'b1;
            end
            D_PWAIT: begin
                if (cnt == '0) st_n = D_PARM;
                else           cnt_n = cnt - 1'b1;
            end
            D_CREL: begin
                if (cnt == '0) begin st_n = D_CBG; cnt_n = PROG_LD; end
                else           cnt_n = cnt - 1'b1;
            end
            default: st_n = D_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= D_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_n;
            cnt <= cnt_n;
        end
    end

    // outputs
    always_comb begin
        rdy  = (st == D_IDLE) || (st == D_CBG) || (st == D_PARM);
        done = (st == D_IDLE);
    end

    assert_done_has_rdy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> rdy);

    assert_no_launch_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> rdy);

    assert_no_erase_unless_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (go && op == OP_ERASE) |-> done);

    assert_prog_ends_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st == D_PROG && cnt == '0) |=> done);

    assert_cache_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == D_CREL && cnt == '0) |=> (rdy && !done));

endmodule

// File: rtl/nand_cmd_front.sv
module nand_cmd_front
    import nand_emul_pkg::*;
#(
    parameter int COL_CYCLES = 2,
    parameter int ROW_CYCLES = 3,
    parameter int DIE_BIT    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cle,
    input  logic                ale,
    input  logic                we,
    input  logic [7:0]          din,
    input  logic [NUM_DIES-1:0] can_prog,
    input  logic [NUM_DIES-1:0] can_erase,
    output logic [NUM_DIES-1:0] go,
    output op_t                 op,
    output logic                sel,
    output logic                proto_err
);

    localparam int AW = $clog2(COL_CYCLES + ROW_CYCLES + 1);
    localparam logic [AW-1:0] PLAST = AW'(COL_CYCLES + ROW_CYCLES - 1);
    localparam logic [AW-1:0] CLAST = AW'(COL_CYCLES - 1);
    localparam logic [AW-1:0] RLAST = AW'(ROW_CYCLES - 1);

    fe_st_t        st, st_n;
    logic [AW-1:0] acnt, acnt_n;
    logic          die, die_n, sel_n, second, second_n, err_n;
    logic          cmd_wr, adr_wr, abit;

    assign cmd_wr = we && cle && !ale;
    assign adr_wr = we && ale && !cle;
    assign abit   = din[DIE_BIT];

    // next state and launch
    always_comb begin
        st_n     = st;
        acnt_n   = acnt;
        die_n    = die;
        sel_n    = sel;
        second_n = second;
        err_n    = 1'b0;
        go       = '0;
        op       = OP_PROG;
        if (cmd_wr) begin
            acnt_n = '0;
            unique case (din)
                CMD_PROG: st_n = F_PADDR;
                CMD_ERASE: begin
                    second_n = (st == F_EWAIT);
                    st_n     = F_EADDR;
                end
                CMD_STAT: st_n = F_SADDR;
                CMD_RAND: begin
                    if (st == F_PDATA) st_n = F_RCOL;
                    else begin err_n = 1'b1; st_n = F_DROP; end
                end
                CMD_CONF, CMD_CACHE, CMD_PLANE: begin
                    st_n = F_IDLE;
                    if (st == F_PDATA) begin
                        go[die] = 1'b1;
                        op = (din == CMD_CONF)  ? OP_PROG :
                             (din == CMD_CACHE) ? OP_CACHE : OP_PLANE;
                    end else if (st != F_DROP) begin
                        err_n = 1'b1;
                    end
                end
                CMD_ECONF: begin
                    st_n = F_IDLE;
                    if (st == F_EWAIT) begin
                        go[die] = 1'b1;
                        op      = OP_ERASE;
                    end else if (st != F_DROP) begin
                        err_n = 1'b1;
                    end
                end
                default: begin
                    st_n  = F_IDLE;
                    err_n = 1'b1;
                end
            endcase
        end else if (adr_wr) begin
            acnt_n = acnt + 1'b1;
            unique case (st)
                F_PADDR: begin
                    if (acnt == PLAST) begin
                        if (can_prog[abit]) begin
                            die_n = abit;
                            st_n  = F_PDATA;
                        end else begin
                            err_n = 1'b1;
                            st_n  = F_DROP;
                        end
                    end
                end
                F_RCOL: begin
                    if (acnt == CLAST) st_n = F_PDATA;
                end
                F_EADDR: begin
                    if (acnt == RLAST) begin
                        if (second) begin
                            st_n = F_EWAIT;
                        end else if (can_erase[abit]) begin
                            die_n = abit;
                            st_n  = F_EWAIT;
                        end else begin
                            err_n = 1'b1;
                            st_n  = F_DROP;
                        end
                    end
                end
                F_SADDR: begin
                    if (acnt == RLAST) begin
                        sel_n = abit;
                        st_n  = F_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= F_IDLE;
            acnt      <= '0;
            die       <= 1'b0;
            sel       <= 1'b0;
            second    <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            st        <= st_n;
            acnt      <= acnt_n;
            die       <= die_n;
            sel       <= sel_n;
            second    <= second_n;
            proto_err <= err_n;
        end
    end

    assert_sel_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !adr_wr |=> $stable(sel));

    assert_err_follows_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(proto_err) |-> $past(we));

endmodule

// File: rtl/dual_die_emul.sv
module dual_die_emul
    import nand_emul_pkg::*;
#(
    parameter int COL_CYCLES = 2,
    parameter int ROW_CYCLES = 3,
    parameter int DIE_BIT    = 2,
    parameter int PROG_T     = 64,
    parameter int ERASE_T    = 256,
    parameter int CACHE_T    = 8,
    parameter int PLANE_T    = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cle,
    input  logic       ale,
    input  logic       we,
    input  logic       re,
    input  logic [7:0] din,
    output logic [7:0] dout,
    output logic       rb,
    output logic       proto_err
);

    logic [NUM_DIES-1:0] rdy, done, go;
    op_t                 op;
    logic                sel;

    nand_cmd_front #(
        .COL_CYCLES(COL_CYCLES),
        .ROW_CYCLES(ROW_CYCLES),
        .DIE_BIT   (DIE_BIT)
    ) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .cle      (cle),
        .ale      (ale),
        .we       (we),
        .din      (din),
        .can_prog (rdy),
        .can_erase(done),
        .go       (go),
        .op       (op),
        .sel      (sel),
        .proto_err(proto_err)
    );

    for (genvar g = 0; g < NUM_DIES; g++) begin : g_die
        nand_die_engine #(
            .PROG_T (PROG_T),
            .ERASE_T(ERASE_T),
            .CACHE_T(CACHE_T),
            .PLANE_T(PLANE_T)
        ) u_die (
            .clk  (clk),
            .rst_n(rst_n),
            .go   (go[g]),
            .op   (op),
            .rdy  (rdy[g]),
            .done (done[g])
        );
    end

    assign rb = &rdy;

    always_ff @(posedge clk) begin
        if (!rst_n)  dout <= 8'h00;
        else if (re) dout <= {1'b0, rdy[sel], done[sel], 5'b00000};
    end

endmodule

// File: tb/dual_die_emul_bench.sv
`timescale 1ns/1ps
module dual_die_emul_bench;

    localparam int PROG_T = 64, ERASE_T = 256, CACHE_T = 8, PLANE_T = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cle = 1'b0, ale = 1'b0, we = 1'b0, re = 1'b0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout;
    logic rb, proto_err;

    int n_chk = 0, n_bad = 0, busy_cnt = 0, base = 0;
    logic re_seen = 1'b0;
    logic [7:0] exp_q[$];
    string tag_q[$];

    always #10 clk = ~clk;

    dual_die_emul u_dual_die_emul (
        .clk(clk), .rst_n(rst_n), .cle(cle), .ale(ale), .we(we), .re(re),
        .din(din), .dout(dout), .rb(rb), .proto_err(proto_err)
    );

    always @(negedge clk) if (rst_n && rb === 1'b0) busy_cnt++;
    always @(posedge clk) re_seen <= re;

    // monitor: compare each captured status byte with the queued expectation
    always @(negedge clk) begin
        if (re_seen) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL %s: actual %02h expected none", "scoreboard", dout);
            end else begin
                logic [7:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (dout !== e) begin
                    n_bad++;
                    $display("FAIL %s: status actual %02h expected %02h", t, dout, e);
                end
            end
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic c, input logic a, input logic [7:0] d);
        @(negedge clk);
        cle = c; ale = a; din = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0; cle = 1'b0; ale = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] d); wr(1'b1, 1'b0, d); endtask
    task automatic adr(input logic [7:0] d); wr(1'b0, 1'b1, d); endtask
    task automatic dat(input logic [7:0] d); wr(1'b0, 1'b0, d); endtask

    task automatic p_addr(input bit d);
        for (int i = 0; i < 4; i++) adr(8'h00);
        adr(d ? 8'h04 : 8'h00);
    endtask

    task automatic r_addr(input bit d);
        adr(8'h00); adr(8'h00); adr(d ? 8'h04 : 8'h00);
    endtask

    task automatic sel_die(input bit d);
        cmd(8'h78); r_addr(d);
    endtask

    task automatic rd(input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk); re = 1'b1;
        @(negedge clk); re = 1'b0;
    endtask

    task automatic wait_ready;
        while (rb !== 1'b1) @(negedge clk);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 reset rb", int'(rb), 1);
        check("R9 reset proto_err", int'(proto_err), 0);
        rd(8'h60, "R6 reset selects die 0");

        // R3 plain program on die 0
        cmd(8'h80); p_addr(1'b0);
        for (int i = 0; i < 4; i++) dat(8'(i));
        base = busy_cnt; cmd(8'h10);
        check("R2 rb low while busy", int'(rb), 0);
        rd(8'h00, "R3 busy status");
        wait_ready();
        check("R3 program busy cycles", busy_cnt - base, PROG_T);
        rd(8'h60, "R3 done status");

        // R1 program on die 1, die 0 untouched
        cmd(8'h80); p_addr(1'b1); dat(8'h11);
        base = busy_cnt; cmd(8'h10);
        sel_die(1'b1); rd(8'h00, "R1 die 1 busy");
        sel_die(1'b0); rd(8'h60, "R1 die 0 unaffected");
        wait_ready();
        check("R1 die 1 busy cycles", busy_cnt - base, PROG_T);
        sel_die(1'b1); rd(8'h60, "R6 die 1 done");

        // R9 random data input
        cmd(8'h80); p_addr(1'b0); dat(8'h01); dat(8'h02);
        cmd(8'h85); adr(8'h10); adr(8'h00); dat(8'h03);
        check("R9 85h in data phase no error", int'(proto_err), 0);
        base = busy_cnt; cmd(8'h10);
        wait_ready();
        check("R9 program after 85h", busy_cnt - base, PROG_T);
        cmd(8'h85);
        check("R9 85h outside data phase", int'(proto_err), 1);
        @(negedge clk);
        check("R9 error is one pulse", int'(proto_err), 0);
        check("R9 nothing launched", int'(rb), 1);

        // R5 cache program on die 0
        cmd(8'h80); p_addr(1'b0); dat(8'hAA);
        base = busy_cnt; cmd(8'h15);
        wait_ready();
        check("R5 cache release cycles", busy_cnt - base, CACHE_T);
        sel_die(1'b0); rd(8'h40, "R5 ready not done");
        cmd(8'h80); p_addr(1'b0);
        check("R5 second cache accepted", int'(proto_err), 0);
        dat(8'hBB);
        base = busy_cnt; cmd(8'h15);
        wait_ready();
        check("R5 second cache release", busy_cnt - base, CACHE_T);
        repeat (PROG_T + 10) @(negedge clk);
        rd(8'h60, "R5 all done after background");

        // R10 program to busy die 1
        cmd(8'h80); p_addr(1'b1); dat(8'h01);
        base = busy_cnt; cmd(8'h10);
        cmd(8'h80); p_addr(1'b1);
        check("R10 program to busy die flagged", int'(proto_err), 1);
        dat(8'h02); cmd(8'h10);
        check("R10 rest of sequence silent", int'(proto_err), 0);
        wait_ready();
        check("R10 timer not restarted", busy_cnt - base, PROG_T);

        // R10 erase to die 0 during background program
        cmd(8'h80); p_addr(1'b0); dat(8'h05); cmd(8'h15);
        wait_ready();
        cmd(8'h60); r_addr(1'b0);
        check("R10 erase to non-idle die flagged", int'(proto_err), 1);
        cmd(8'hD0);
        check("R10 erase confirm ignored", int'(rb), 1);
        repeat (PROG_T + 10) @(negedge clk);

        // R7 two-plane program on die 1
        cmd(8'h80); p_addr(1'b1); dat(8'h07);
        base = busy_cnt; cmd(8'h11);
        wait_ready();
        check("R7 plane dummy busy", busy_cnt - base, PLANE_T);
        sel_die(1'b1); rd(8'h40, "R7 awaiting second plane");
        cmd(8'h80); p_addr(1'b1);
        check("R7 second plane accepted", int'(proto_err), 0);
        dat(8'h08);
        base = busy_cnt; cmd(8'h10);
        wait_ready();
        check("R7 second plane program", busy_cnt - base, PROG_T);
        rd(8'h60, "R7 done");

        // R8 erase, single and two-plane, die 0
        cmd(8'h60); r_addr(1'b0);
        base = busy_cnt; cmd(8'hD0);
        wait_ready();
        check("R8 erase busy cycles", busy_cnt - base, ERASE_T);
        cmd(8'h60); r_addr(1'b0); cmd(8'h60); r_addr(1'b0);
        check("R8 second group accepted", int'(proto_err), 0);
        base = busy_cnt; cmd(8'hD0);
        wait_ready();
        check("R8 two-plane erase cycles", busy_cnt - base, ERASE_T);
        sel_die(1'b0); rd(8'h60, "R8 done");

        // R11 interleave: program die 0, then erase die 1
        cmd(8'h80); p_addr(1'b0); dat(8'h09);
        base = busy_cnt; cmd(8'h10);
        cmd(8'h60); r_addr(1'b1); cmd(8'hD0);
        check("R11 erase to idle die accepted", int'(proto_err), 0);
        repeat (PROG_T) @(negedge clk);
        sel_die(1'b0); rd(8'h60, "R11 die 0 finished");
        sel_die(1'b1); rd(8'h00, "R11 die 1 still erasing");
        check("R11 rb low while die 1 busy", int'(rb), 0);
        wait_ready();
        check("R11 shared busy span", busy_cnt - base, 10 + ERASE_T);

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
        end
        summary();
        $finish;
    end

endmodule